// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Character Queue

This block turns an asynchronous serial line into a queue of characters. A sample enable pulses sixteen times per bit period. The receiver watches the line during idle for a falling edge and confirms a start bit at the middle of that bit. It then collects five to eight data bits, least significant bit first, plus an optional parity bit and the stop bit. Each character goes into a 64-entry queue. Every entry carries three error tags next to its data byte: parity error, framing error and break.

The host sees the oldest entry on the read outputs and advances the queue with a one-cycle pop pulse. A level output tells the host how many characters are waiting. A data interrupt fires when the level reaches a trigger chosen from a four-entry table. A line-status interrupt fires in one of two ways, chosen by configuration. In deferred mode it waits until a tagged character is the oldest entry. In early mode it fires as soon as a tagged character is stored, and stays up until the host reads status. A sticky overrun flag records a character that was dropped because the queue was full.

The frame state machine has six states:
- `ST_IDLE` moves to `ST_START` on a low sample.
- `ST_START` goes back to `ST_IDLE` if the line is high at mid-bit (a glitch), and moves to `ST_DATA` otherwise.
- `ST_DATA` moves to `ST_PARITY` after the last data bit when parity is on, and to `ST_STOP` when it is off.
- `ST_PARITY` moves to `ST_STOP`.
- `ST_STOP` moves to `ST_IDLE` on a high stop sample, and to `ST_HOLD_LOW` on a low one.
- `ST_HOLD_LOW` moves to `ST_IDLE` once the line is sampled high.

Top module: `rx_tagged_fifo`

## Requirements
- R1: A low on `rxd` seen in idle is confirmed on the 8th sample enable after it. If the line is high at that point, nothing is stored and the receiver returns to idle.
- R2: `cfg_wlen` selects the data bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, and the unused upper bits of the stored byte read as zero.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_even`=1 expects an even count of ones over data and parity, and 0 expects an odd count. A mismatch sets the parity tag (`rd_perr`) of that entry.
- R4: A stop bit sampled low sets the framing tag (`rd_ferr`) of the stored entry. The data bits are kept as received.
- R5: A frame in which every sample, from the start bit through the stop bit, is low stores exactly one entry with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. No further character is started until the line has been seen high.
- R6: The queue holds 64 entries in arrival order. The oldest entry is shown on `rd_data`/`rd_perr`/`rd_ferr`/`rd_brk` while `data_ready`=1. A `pop` pulse removes it, and `level` reports the count of stored entries. A store and a pop in the same cycle leave `level` unchanged.
- R7: A `pop` while the queue is empty leaves `level` at 0. The read outputs then keep showing the entry that was popped last.
- R8: A character that completes while 64 entries are stored is dropped and sets `overrun`, which also raises `line_irq`. `overrun` stays set until a `lsr_read` pulse. If a new overrun arrives in the same cycle as that pulse, the flag stays set.
- R9: `cfg_trig_sel` picks the receive trigger level: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 56. `rx_data_irq` is 1 exactly while `level` is at or above that trigger.
- R10: With `cfg_lsi_early`=0, `line_irq` (apart from overrun) is 1 only while the oldest stored entry carries any error tag.
- R11: With `cfg_lsi_early`=1, storing an entry that has any error tag sets `line_irq` at once, whatever entry is oldest. It stays set until a `lsr_read` pulse or a queue clear.
- R12: A `fifo_clear` pulse empties the queue (level 0) only while `cfg_fifo_en`=1. With `cfg_fifo_en`=0 the pulse has no effect on the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Sample enable, 16 per bit period |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_wlen | input | 2 | Data bit count code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_fifo_en | input | 1 | Enables the clear command |
| cfg_trig_sel | input | 2 | Trigger table index |
| cfg_lsi_early | input | 1 | 1 = line interrupt raised when a tagged character is stored |
| fifo_clear | input | 1 | Clear command pulse |
| pop | input | 1 | Remove the oldest entry |
| lsr_read | input | 1 | Status read pulse; clears sticky flags |
| rd_data | output | 8 | Data byte of the oldest entry |
| rd_perr | output | 1 | Parity tag of the oldest entry |
| rd_ferr | output | 1 | Framing tag of the oldest entry |
| rd_brk | output | 1 | Break tag of the oldest entry |
| level | output | 7 | Number of stored entries |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun flag |
| rx_data_irq | output | 1 | Level at or above trigger |
| line_irq | output | 1 | Line-status interrupt |

## Verification
The assertions rely on `pop`, `lsr_read` and `fifo_clear` being pulses driven away from the clock edge. They also rely on the configuration being held steady while a frame is in flight, so that the tags of a stored entry match the settings in force when it arrived. The stimulus changes configuration only while the line is idle, after the previous frame has been stored. It drives every bit for a whole 16-sample period, so each sample point lands well inside its bit. Glitch and break patterns are built from the same bit-period units, which places their mid-bit and stop samples deterministically.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_HOLD_LOW
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    function automatic logic [3:0] wlen_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/rxq_deframer.sv
module rxq_deframer
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic [1:0] cfg_wlen,
    input  logic      cfg_par_en,
    input  logic      cfg_par_even,
    output logic      push,
    output rx_entry_t entry
);

    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

    rx_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    sreg;
    logic          par_bit;
    logic          all_low;
    logic          sample_pt;
    logic          last_bit;

    assign sample_pt = tick && (cnt == LAST_C);
    assign last_bit  = ({1'b0, bit_idx} == (wlen_bits(cfg_wlen) - 4'd1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (tick && !rxd)          nxt = ST_START;
            ST_START:    if (tick && cnt == MID_C)  nxt = rxd ? ST_IDLE : ST_DATA;
            ST_DATA:     if (sample_pt && last_bit) nxt = cfg_par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:   if (sample_pt)             nxt = ST_STOP;
            ST_STOP:     if (sample_pt)             nxt = rxd ? ST_IDLE : ST_HOLD_LOW;
            ST_HOLD_LOW: if (tick && rxd)           nxt = ST_IDLE;
            default:                                nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            sreg    <= '0;
            par_bit <= 1'b0;
            all_low <= 1'b1;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        cnt     <= '0;
                        bit_idx <= '0;
                        sreg    <= '0;
                        par_bit <= 1'b0;
                        all_low <= 1'b1;
                    end
                    ST_START: begin
                        cnt <= (cnt == MID_C) ? '0 : cnt + 1'b1;
                    end
                    ST_DATA: begin
                        cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
                        if (cnt == LAST_C) begin
                            sreg[bit_idx] <= rxd;
                            bit_idx       <= bit_idx + 1'b1;
                            if (rxd) all_low <= 1'b0;
                        end
                    end
                    ST_PARITY: begin
                        cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
                        if (cnt == LAST_C) begin
                            par_bit <= rxd;
                            if (rxd) all_low <= 1'b0;
                        end
                    end
                    ST_STOP: begin
                        cnt <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
                        if (cnt == LAST_C) begin
                            push       <= 1'b1;
                            entry.data <= sreg;
                            entry.ferr <= !rxd;
                            entry.brk  <= all_low && !rxd;
                            entry.perr <= !(all_low && !rxd) && cfg_par_en &&
                                          (^sreg ^ par_bit ^ !cfg_par_even);
                        end
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    parameter int W     = 11,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    input  logic          clear,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          push_ok,
    output logic          push_drop
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] TOP_C  = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_C = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [W-1:0]  last_q;
    logic          full, pop_ok;

    assign empty     = (level == '0);
    assign full      = (level == FULL_C);
    assign push_ok   = push && !full && !clear;
    assign push_drop = push && full && !clear;
    assign pop_ok    = pop && !empty && !clear;
    assign head      = empty ? last_q : mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            level  <= '0;
            last_q <= '0;
        end else if (clear) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == TOP_C) ? '0 : wptr + 1'b1;
            if (pop_ok) begin
                rptr   <= (rptr == TOP_C) ? '0 : rptr + 1'b1;
                last_q <= mem[rptr];
            end
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic          empty,
    input  logic          head_err,
    input  logic          push_ok,
    input  logic          push_err,
    input  logic          push_drop,
    input  logic          lsr_read,
    input  logic          clear_ok,
    input  logic [1:0]    trig_sel,
    input  logic          lsi_early,
    output logic          overrun,
    output logic          rx_data_irq,
    output logic          line_irq
);

    localparam int NTRIG = 4;
    logic [LW-1:0] trig_tab [NTRIG];
    logic          err_seen;

    genvar g;
    generate
        for (g = 0; g < NTRIG; g++) begin : g_trig
            if (g == 0)      begin : g_t0 assign trig_tab[g] = LW'(1);         end
            else if (g == 1) begin : g_t1 assign trig_tab[g] = LW'(DEPTH / 4); end
            else if (g == 2) begin : g_t2 assign trig_tab[g] = LW'(DEPTH / 2); end
            else             begin : g_t3 assign trig_tab[g] = LW'(DEPTH - 8); end
        end
    endgenerate

    assign rx_data_irq = (level >= trig_tab[trig_sel]);
    assign line_irq    = overrun | (lsi_early ? err_seen : (!empty && head_err));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun  <= 1'b0;
            err_seen <= 1'b0;
        end else begin
            if (push_drop)     overrun <= 1'b1;
            else if (lsr_read) overrun <= 1'b0;

            if (push_ok && push_err)     err_seen <= 1'b1;
            else if (lsr_read || clear_ok) err_seen <= 1'b0;
        end
    end

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [1:0]    cfg_wlen,
    input  logic          cfg_par_en,
    input  logic          cfg_par_even,
    input  logic          cfg_fifo_en,
    input  logic [1:0]    cfg_trig_sel,
    input  logic          cfg_lsi_early,
    input  logic          fifo_clear,
    input  logic          pop,
    input  logic          lsr_read,
    output logic [7:0]    rd_data,
    output logic          rd_perr,
    output logic          rd_ferr,
    output logic          rd_brk,
    output logic [LW-1:0] level,
    output logic          data_ready,
    output logic          overrun,
    output logic          rx_data_irq,
    output logic          line_irq
);

    rx_entry_t new_entry, head_entry;
    logic      new_push, push_ok, push_drop, empty, clear_ok;
    logic [ENTRY_W-1:0] head_bits;

    assign clear_ok   = fifo_clear && cfg_fifo_en;
    assign head_entry = rx_entry_t'(head_bits);
    assign rd_data    = head_entry.data;
    assign rd_perr    = head_entry.perr;
    assign rd_ferr    = head_entry.ferr;
    assign rd_brk     = head_entry.brk;
    assign data_ready = !empty;

    rxq_deframer #(.OSR(OSR)) u_deframer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .rxd          (rxd),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_even (cfg_par_even),
        .push         (new_push),
        .entry        (new_entry)
    );

    rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W), .LW(LW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (new_push),
        .wdata     (new_entry),
        .pop       (pop),
        .clear     (clear_ok),
        .head      (head_bits),
        .level     (level),
        .empty     (empty),
        .push_ok   (push_ok),
        .push_drop (push_drop)
    );

    rxq_status #(.DEPTH(DEPTH), .LW(LW)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level),
        .empty       (empty),
        .head_err    (head_entry.perr | head_entry.ferr | head_entry.brk),
        .push_ok     (push_ok),
        .push_err    (new_entry.perr | new_entry.ferr | new_entry.brk),
        .push_drop   (push_drop),
        .lsr_read    (lsr_read),
        .clear_ok    (clear_ok),
        .trig_sel    (cfg_trig_sel),
        .lsi_early   (cfg_lsi_early),
        .overrun     (overrun),
        .rx_data_irq (rx_data_irq),
        .line_irq    (line_irq)
    );

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pop,
    input logic          lsr_read,
    input logic          cfg_lsi_early,
    input logic [7:0]    rd_data,
    input logic          rd_perr,
    input logic          rd_ferr,
    input logic          rd_brk,
    input logic [LW-1:0] level,
    input logic          data_ready,
    input logic          overrun,
    input logic          rx_data_irq,
    input logic          line_irq
);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R6
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1 ||
                  level + 1'b1 == $past(level) || level == '0));

    // R6
    ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (level != '0));

    // R5
    brk_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && rd_brk) |-> (rd_ferr && !rd_perr && rd_data == 8'h00));

    // R7
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !data_ready) |=> (data_ready || rd_data == $past(rd_data)));

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_read) |=> overrun);

    // R8
    overrun_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> line_irq);

    // R9
    trig_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_irq |-> data_ready);

    // R10
    deferred_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_lsi_early && !overrun && !(data_ready && (rd_perr || rd_ferr || rd_brk)))
            |-> !line_irq);

endmodule

bind rx_tagged_fifo rxq_chk #(.DEPTH(DEPTH), .LW(LW)) u_rxq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pop           (pop),
    .lsr_read      (lsr_read),
    .cfg_lsi_early (cfg_lsi_early),
    .rd_data       (rd_data),
    .rd_perr       (rd_perr),
    .rd_ferr       (rd_ferr),
    .rd_brk        (rd_brk),
    .level         (level),
    .data_ready    (data_ready),
    .overrun       (overrun),
    .rx_data_irq   (rx_data_irq),
    .line_irq      (line_irq)
);

// File: tb/test_rx_tagged_fifo.sv
module test_rx_tagged_fifo;

    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_fifo_en = 1'b1;
    logic [1:0] cfg_trig_sel = 2'd0;
    logic       cfg_lsi_early = 1'b0;
    logic       fifo_clear = 1'b0;
    logic       pop = 1'b0;
    logic       lsr_read = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk;
    logic [6:0] level;
    logic       data_ready, overrun, rx_data_irq, line_irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [10:0] exp_q [$];

    rx_tagged_fifo i_rx_tagged_fifo (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_fifo_en(cfg_fifo_en), .cfg_trig_sel(cfg_trig_sel),
        .cfg_lsi_early(cfg_lsi_early), .fifo_clear(fifo_clear), .pop(pop),
        .lsr_read(lsr_read), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .level(level),
        .data_ready(data_ready), .overrun(overrun),
        .rx_data_irq(rx_data_irq), .line_irq(line_irq)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(negedge clk);
        tick16 = ~tick16;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v, input int nbits);
        rxd = v;
        repeat (nbits * BITCLK) @(negedge clk);
    endtask

    // driver: sends one frame and records the expected entry
    task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v, input bit record);
        int nb;
        logic [7:0] m;
        logic p;
        nb = 5 + int'(cfg_wlen);
        m = 8'((9'd1 << nb) - 9'd1);
        p = ^(d & m) ^ !cfg_par_even ^ bad_par;
        bit_time(1'b0, 1);
        for (int i = 0; i < nb; i++) bit_time(d[i], 1);
        if (cfg_par_en) bit_time(p, 1);
        bit_time(stop_v, 1);
        bit_time(1'b1, 1);
        if (record)
            exp_q.push_back({1'b0, !stop_v, cfg_par_en && bad_par, d & m});
    endtask

    // monitor: pops one entry and compares it with the oldest expected
    task automatic pop_one(input string req);
        logic [10:0] e;
        @(negedge clk);
        if (exp_q.size() == 0) begin
            chk(req, {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, 32'hFFF);
        end else begin
            e = exp_q.pop_front();
            chk(req, {21'd0, rd_brk, rd_ferr, rd_perr, rd_data}, {21'd0, e});
        end
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        while (data_ready) pop_one(req);
        chk({req, " queue empty"}, 32'(exp_q.size()), 0);
    endtask

    task automatic pulse_lsr();
        @(negedge clk);
        lsr_read = 1'b1;
        @(negedge clk);
        lsr_read = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset level", 32'(level), 0);
        chk("R6 reset ready", 32'(data_ready), 0);
        chk("R8 reset overrun", 32'(overrun), 0);
        chk("R10 reset line_irq", 32'(line_irq), 0);
        chk("R9 reset rx_data_irq", 32'(rx_data_irq), 0);

        // R6 order and level, R9 trigger of 1
        send(8'hA5, 0, 1, 1);
        send(8'h3C, 0, 1, 1);
        @(negedge clk);
        chk("R6 level two", 32'(level), 2);
        chk("R9 trig1 irq", 32'(rx_data_irq), 1);
        drain("R6 order");

        // R7 pop on empty
        chk("R7 last data", 32'(rd_data), 32'h3C);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
        chk("R7 level stays", 32'(level), 0);
        chk("R7 data held", 32'(rd_data), 32'h3C);

        // R2 word lengths
        cfg_wlen = 2'd0;
        send(8'hFF, 0, 1, 1);
        cfg_wlen = 2'd2;
        send(8'hC3, 0, 1, 1);
        cfg_wlen = 2'd1;
        send(8'h6A, 0, 1, 1);
        drain("R2 wlen");

        // R3 parity, R10 deferred line interrupt
        cfg_wlen = 2'd3;
        cfg_par_en = 1'b1;
        cfg_par_even = 1'b1;
        send(8'h96, 0, 1, 1);
        send(8'h97, 1, 1, 1);
        @(negedge clk);
        chk("R10 head clean no irq", 32'(line_irq), 0);
        pop_one("R3 even good");
        @(negedge clk);
        chk("R10 tagged head irq", 32'(line_irq), 1);
        pop_one("R3 even bad");
        @(negedge clk);
        chk("R10 empty no irq", 32'(line_irq), 0);
        cfg_par_even = 1'b0;
        send(8'h01, 0, 1, 1);
        send(8'h01, 1, 1, 1);
        drain("R3 odd");

        // R11 early line interrupt
        cfg_lsi_early = 1'b1;
        send(8'h01, 0, 1, 1);
        send(8'h02, 1, 1, 1);
        @(negedge clk);
        chk("R11 early irq", 32'(line_irq), 1);
        pulse_lsr();
        @(negedge clk);
        chk("R11 cleared by read", 32'(line_irq), 0);
        drain("R11 data");
        cfg_lsi_early = 1'b0;
        cfg_par_en = 1'b0;

        // R4 framing
        send(8'h55, 0, 0, 1);
        drain("R4 framing");

        // R5 break
        bit_time(1'b0, 12);
        bit_time(1'b1, 2);
        exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
        chk("R5 single entry", 32'(level), 1);
        drain("R5 break");

        // R1 glitch
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        bit_time(1'b1, 2);
        chk("R1 glitch ignored", 32'(level), 0);
        send(8'h81, 0, 1, 1);
        drain("R1 after glitch");

        // R9 trigger table, R8 overrun
        cfg_trig_sel = 2'd1;
        for (int i = 0; i < 15; i++) send(8'(i + 16), 0, 1, 1);
        @(negedge clk);
        chk("R9 below 16", 32'(rx_data_irq), 0);
        send(8'h2F, 0, 1, 1);
        @(negedge clk);
        chk("R9 at 16", 32'(rx_data_irq), 1);
        for (int i = 0; i < 48; i++) send(8'(i + 64), 0, 1, 1);
        @(negedge clk);
        chk("R6 full level", 32'(level), 64);
        cfg_trig_sel = 2'd3;
        @(negedge clk);
        chk("R9 trig 56", 32'(rx_data_irq), 1);
        send(8'hEE, 0, 1, 0);
        @(negedge clk);
        chk("R8 dropped level", 32'(level), 64);
        chk("R8 overrun set", 32'(overrun), 1);
        chk("R8 line irq", 32'(line_irq), 1);
        pulse_lsr();
        @(negedge clk);
        chk("R8 overrun cleared", 32'(overrun), 0);

        // R12 clear ignored while disabled
        cfg_fifo_en = 1'b0;
        @(negedge clk);
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        @(negedge clk);
        chk("R12 clear ignored", 32'(level), 64);
        drain("R8 kept entries");

        // R12 clear honoured
        cfg_fifo_en = 1'b1;
        send(8'h11, 0, 1, 0);
        send(8'h22, 0, 1, 0);
        @(negedge clk);
        chk("R12 before clear", 32'(level), 2);
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        @(negedge clk);
        chk("R12 cleared level", 32'(level), 0);
        chk("R12 cleared ready", 32'(data_ready), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule